// File: doc/BRIEF.md
# Successive-Approximation Converter Control Sequencer

This block is the digital control section of a 12-bit successive-approximation analog-to-digital converter. It watches three active-level controls (a chip enable that is active high, a chip select that is active low and a read/convert line that starts a conversion when low) and an address bit that picks which part of the result to read. When all three controls reach their convert levels, the block clears its approximation register and resolves the result one bit per step, most significant bit first. Each step presents a trial code to an external DAC and takes one decision bit back from an external comparator. A busy output stays high for the whole conversion.

The finished code goes into an output latch. It is read over an 8-bit bus in two parts: the upper eight bits, or the lower four bits with the remaining bus lines at zero. The bus is driven only during a valid read and never while a conversion is in progress. All control inputs are asynchronous and are synchronised to the one system clock. The step rate is a parameter that divides the system clock.

Top module: `sar_ctl_top`

## Requirements
- R1: A conversion starts when the chip enable is high, the chip select is low and read/convert is low at the same time. Whichever of the three reaches its level last triggers the start: read/convert falling, chip enable rising or chip select falling.
- R2: While the chip enable is low, or while the chip select is high, no conversion starts and `db_oe_o` stays 0.
- R3: On start the approximation register is cleared. The first trial code on `dac_code_o` is 0x800. Bits are then resolved from bit 11 down to bit 0, one per STEP_DIV clocks, so busy stays high for exactly 12*STEP_DIV+1 clock cycles (49 with the default of 4). A comparator input of 1 keeps the trial bit.
- R4: A start condition that arises while busy is high is ignored. The conversion neither restarts nor changes length, and its result is unaffected.
- R5: Busy rises one clock after the start is detected, which is the third rising clock edge after the triggering input change. Busy falls only after the end-of-conversion cycle.
- R6: The result is straight offset binary: code 0x000 is the bottom of the range and 0xFFF is full scale. It equals the code that the comparator decisions resolve. The output latch is loaded one cycle before busy falls and is otherwise held.
- R7: `db_oe_o` is 1 only when read/convert is high, busy is low, the chip enable is high and the chip select is low. It follows the inputs with a latency of three clocks and is never 1 while busy is high.
- R8: With `a0_i` low, a read puts result bits 11..4 on `db_o[7:0]`, with bit 11 on `db_o[7]`. With `a0_i` high, a read puts result bits 3..0 on `db_o[3:0]` and drives `db_o[7:4]` to 0.
- R9: After reset, busy is low, `db_oe_o` is 0 and `dac_code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_i | input | 1 | Chip enable, active high, asynchronous |
| cs_i | input | 1 | Chip select, active low, asynchronous |
| rc_i | input | 1 | Read (high) / convert (low), asynchronous |
| a0_i | input | 1 | Read part select: 0 for upper eight bits, 1 for lower four bits |
| cmp_i | input | 1 | Comparator decision for the current trial code |
| dac_code_o | output | 12 | Trial code for the DAC during conversion; result when idle |
| busy_o | output | 1 | High while a conversion runs |
| db_o | output | 8 | Data bus value |
| db_oe_o | output | 1 | Data bus drive enable; 0 means high impedance |

## Verification
The hardest case to reach from the ports is a second start condition that appears while a conversion is already running. A working design gives no sign of it at the ports: busy simply stays high and the result is unchanged. To reach it, the bench forks a thread that raises read/convert in the middle of a conversion and then lowers it again, which makes the combined start predicate rise a second time. A parallel thread counts the cycles during which busy is high. The bench then checks that this count and the value read back both match an undisturbed conversion. The rest of the stimulus covers each of the three trigger orders, the two disabled conditions and the extreme codes at the ends of the range.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;
  localparam int DEF_RES_BITS = 12;
  localparam int DEF_BUS_BITS = 8;
  localparam int DEF_STEP_DIV = 4;
  localparam int DEF_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_EOC  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= RST_VAL;
          else        stg_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= RST_VAL;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sar_start_det.sv
module sar_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_i,
  input  logic cs_i,
  input  logic rc_i,
  input  logic busy_i,
  output logic start_o
);
  logic conv_pred;
  logic pred_q;

  assign conv_pred = ce_i & ~cs_i & ~rc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pred_q <= 1'b0;
    else        pred_q <= conv_pred;
  end

  assign start_o = conv_pred & ~pred_q & ~busy_i;
endmodule

// File: rtl/sar_step_div.sv
module sar_step_div #(
  parameter int STEP_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic step_o
);
  localparam int CW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign step_o = run_i && (cnt_q == LAST);
  assign cnt_en = clr_i | run_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                cnt_d = '0;
    else if (cnt_q == LAST)   cnt_d = '0;
    else                      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_ctl_pkg::*;
#(
  parameter int RES_BITS = DEF_RES_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                step_i,
  input  logic                cmp_i,
  output logic                busy_o,
  output logic                run_o,
  output logic [RES_BITS-1:0] trial_o,
  output logic [RES_BITS-1:0] result_o
);
  localparam int IW = $clog2(RES_BITS);
  localparam logic [IW-1:0] TOP_IDX = IW'(RES_BITS - 1);

  seq_state_e          state_q, state_d;
  logic [IW-1:0]       idx_q, idx_d;
  logic [RES_BITS-1:0] sar_q, sar_d;
  logic [RES_BITS-1:0] res_q, res_d;
  logic                last_step;

  assign last_step = (state_q == ST_RUN) && step_i && (idx_q == '0);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    sar_d   = sar_q;
    res_d   = res_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          sar_d   = '0;
          idx_d   = TOP_IDX;
        end
      end
      ST_RUN: begin
        if (step_i) begin
          sar_d[idx_q] = cmp_i;
          if (idx_q == '0) begin
            state_d = ST_EOC;
            res_d   = sar_d;
          end else begin
            idx_d = idx_q - IW'(1);
          end
        end
      end
      ST_EOC:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sar_q   <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sar_q   <= sar_d;
      res_q   <= res_d;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign run_o    = (state_q == ST_RUN);
  assign trial_o  = (state_q == ST_RUN) ? (sar_q | (RES_BITS'(1) << idx_q)) : sar_q;
  assign result_o = res_q;

  AST_SAR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q == ST_IDLE) |=> (sar_q == '0 && idx_q == TOP_IDX)); // R3
  AST_STATUS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o); // R5
  AST_EOC_BEFORE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(state_q == ST_EOC)); // R5
  AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !last_step |=> $stable(res_q)); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !step_i) |=> (state_q == ST_RUN && $stable(idx_q))); // R4
endmodule

// File: rtl/sar_read_port.sv
module sar_read_port #(
  parameter int RES_BITS = 12,
  parameter int BUS_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_i,
  input  logic                cs_i,
  input  logic                rc_i,
  input  logic                a0_i,
  input  logic                busy_i,
  input  logic [RES_BITS-1:0] result_i,
  output logic [BUS_BITS-1:0] db_o,
  output logic                oe_o
);
  localparam int LSB_BITS = RES_BITS - BUS_BITS;

  logic                read_ok;
  logic [BUS_BITS-1:0] db_d, db_q;
  logic                oe_q, sel_q;

  assign read_ok = rc_i & ~busy_i & ce_i & ~cs_i;

  always_comb begin
    if (!read_ok)  db_d = '0;
    else if (a0_i) db_d = BUS_BITS'(result_i[LSB_BITS-1:0]);
    else           db_d = result_i[RES_BITS-1 -: BUS_BITS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      db_q  <= '0;
      sel_q <= 1'b0;
    end else begin
      oe_q  <= read_ok;
      db_q  <= db_d;
      sel_q <= a0_i;
    end
  end

  assign db_o = db_q;
  assign oe_o = oe_q;

  AST_BUS_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> !busy_i); // R7
  AST_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && sel_q) |-> (db_q[BUS_BITS-1:LSB_BITS] == '0)); // R8
endmodule

// File: rtl/sar_ctl_top.sv
module sar_ctl_top
  import sar_ctl_pkg::*;
#(
  parameter int RES_BITS = DEF_RES_BITS,
  parameter int BUS_BITS = DEF_BUS_BITS,
  parameter int STEP_DIV = DEF_STEP_DIV,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_i,
  input  logic                cs_i,
  input  logic                rc_i,
  input  logic                a0_i,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic                busy_o,
  output logic [BUS_BITS-1:0] db_o,
  output logic                db_oe_o
);
  logic rst_meta_q, rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sn     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sn     <= rst_meta_q;
    end
  end

  logic [3:0] ctl_raw, ctl_s;
  logic       ce_s, cs_s, rc_s, a0_s;
  logic       start, step, busy, run;
  logic [RES_BITS-1:0] result;

  assign ctl_raw = {ce_i, cs_i, rc_i, a0_i};
  assign {ce_s, cs_s, rc_s, a0_s} = ctl_s;

  sar_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0110)) i_sync (
    .clk(clk), .rst_n(rst_sn), .d_i(ctl_raw), .q_o(ctl_s)
  );

  sar_start_det i_start (
    .clk(clk), .rst_n(rst_sn), .ce_i(ce_s), .cs_i(cs_s), .rc_i(rc_s),
    .busy_i(busy), .start_o(start)
  );

  sar_step_div #(.STEP_DIV(STEP_DIV)) i_div (
    .clk(clk), .rst_n(rst_sn), .clr_i(start), .run_i(run), .step_o(step)
  );

  sar_engine #(.RES_BITS(RES_BITS)) i_engine (
    .clk(clk), .rst_n(rst_sn), .start_i(start), .step_i(step), .cmp_i(cmp_i),
    .busy_o(busy), .run_o(run), .trial_o(dac_code_o), .result_o(result)
  );

  sar_read_port #(.RES_BITS(RES_BITS), .BUS_BITS(BUS_BITS)) i_read (
    .clk(clk), .rst_n(rst_sn), .ce_i(ce_s), .cs_i(cs_s), .rc_i(rc_s), .a0_i(a0_s),
    .busy_i(busy), .result_i(result), .db_o(db_o), .oe_o(db_oe_o)
  );

  assign busy_o = busy;

  AST_START_NEEDS_LEVELS: assert property (@(posedge clk) disable iff (!rst_sn)
    start |-> (ce_s && !cs_s && !rc_s)); // R1
  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_sn)
    (!ce_s || cs_s) |=> !$rose(busy)); // R2
endmodule

// File: tb/test_sar_ctl_top.sv
module test_sar_ctl_top;
  localparam int CLK_PERIOD = 10;
  localparam int CONV_CYC = 12 * 4 + 1;
  localparam int WD_LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce, cs, rc, a0;
  logic [11:0] target;
  logic        cmp;
  logic [11:0] dac_code;
  logic        busy;
  logic [7:0]  db;
  logic        db_oe;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp = (target >= dac_code);

  sar_ctl_top i_sar_ctl_top (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .cs_i(cs), .rc_i(rc), .a0_i(a0),
    .cmp_i(cmp), .dac_code_o(dac_code), .busy_o(busy), .db_o(db), .db_oe_o(db_oe)
  );

  // {trigger mode, target}: mode 0 = R/C last, 1 = CE last, 2 = CS last
  localparam logic [13:0] VEC [8] = '{
    {2'd0, 12'h000}, {2'd1, 12'hFFF}, {2'd2, 12'h800}, {2'd0, 12'h7FF},
    {2'd1, 12'hA5C}, {2'd2, 12'h001}, {2'd0, 12'h3C6}, {2'd1, 12'hFFE}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic trigger(input logic [1:0] mode);
    case (mode)
      2'd1: begin ce = 1'b0; rc = 1'b0; tick(4); ce = 1'b1; end
      2'd2: begin cs = 1'b1; rc = 1'b0; tick(4); cs = 1'b0; end
      default: rc = 1'b0;
    endcase
  endtask

  task automatic count_busy(output int n);
    n = 1;
    while (busy) begin
      tick(1);
      if (busy) n++;
    end
  endtask

  task automatic read_back(input logic [11:0] t, input string req);
    rc = 1'b1; a0 = 1'b0;
    tick(5);
    chk({req, " R7 oe on read"}, 32'(db_oe), 32'd1);
    chk({req, " R8 upper bits"}, 32'(db), 32'(t[11:4]));
    a0 = 1'b1;
    tick(5);
    chk({req, " R8 lower bits"}, 32'(db), 32'({4'b0, t[3:0]}));
    a0 = 1'b0;
    tick(2);
  endtask

  initial begin
    while (cyc < WD_LIMIT) @(posedge clk) cyc++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, WD_LIMIT);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; ce = 1'b1; cs = 1'b0; rc = 1'b1; a0 = 1'b0; target = 12'h000;
    tick(5);
    rst_n = 1'b1;
    tick(1);
    chk("R9 busy after reset", 32'(busy), 32'd0);
    chk("R9 oe after reset", 32'(db_oe), 32'd0);
    chk("R9 dac after reset", 32'(dac_code), 32'd0);
    tick(6);

    for (int v = 0; v < 8; v++) begin
      target = VEC[v][11:0];
      trigger(VEC[v][13:12]);
      tick(2);
      chk("R5 busy low at 2nd edge", 32'(busy), 32'd0);
      tick(1);
      chk("R1/R5 busy high at 3rd edge", 32'(busy), 32'd1);
      chk("R3 first trial code", 32'(dac_code), 32'h800);
      count_busy(n);
      chk("R3 busy length", 32'(n), 32'(CONV_CYC));
      read_back(VEC[v][11:0], "R6");
    end

    // R2: CE low blocks start and reads
    ce = 1'b0; rc = 1'b0; n = 0;
    for (int i = 0; i < 20; i++) begin tick(1); if (busy) n++; end
    chk("R2 no start with CE low", 32'(n), 32'd0);
    rc = 1'b1; tick(5);
    chk("R2 no drive with CE low", 32'(db_oe), 32'd0);
    ce = 1'b1; tick(5);

    // R2: CS high blocks start and reads
    cs = 1'b1; rc = 1'b0; n = 0;
    for (int i = 0; i < 20; i++) begin tick(1); if (busy) n++; end
    chk("R2 no start with CS high", 32'(n), 32'd0);
    rc = 1'b1; tick(5);
    chk("R2 no drive with CS high", 32'(db_oe), 32'd0);
    cs = 1'b0; tick(5);

    // R4: start condition reappears mid-conversion
    target = 12'h5A3;
    rc = 1'b0;
    tick(3);
    chk("R4 conversion running", 32'(busy), 32'd1);
    fork
      count_busy(n);
      begin
        tick(10); rc = 1'b1; tick(4);
        chk("R7 bus quiet while busy", 32'(db_oe), 32'd0);
        rc = 1'b0;
      end
    join
    chk("R4 busy length with retrigger", 32'(n), 32'(CONV_CYC));
    read_back(12'h5A3, "R4");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule